// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the register-side slave of a single DMA channel. It keeps four 32-bit words: a control/status word, a byte address counter and two general-purpose registers. The bus accesses them only as whole words. The control/status word drives three outputs toward the attached peripheral and the system:

- a gated interrupt line;
- a level enable for the DMA engine;
- a one-cycle reset strobe.

The peripheral reports its interrupt as a level. The transfer engine reports each finished transfer with a strobe and a byte count, and the address counter advances by that count.

The status word has special write rules. Its upper version field is hard-wired. Its read-only bits survive any write. A write with the channel-reset bit set fires the strobe. Without that bit, a drain request is self-clearing, and a write of all zeros becomes a drain request. The address counter is loaded by a bus write. Loading it also marks the status word as "address loaded".

Reads are combinational. Writes commit at the next rising clock edge.

Top module: `dma_chan_regs`

## Requirements
- R1: The register is chosen by `req_addr[3:2]`: 0 is status, 1 is address counter, 2 and 3 are general registers. `req_addr[4]` is ignored, so offsets 0x10 to 0x1C alias offsets 0x00 to 0x0C.
- R2: After reset the status word reads 0xA0000000 and the other three registers read 0. The interrupt, enable and strobe outputs are low.
- R3: A status write keeps the bits under mask 0xFE000007 at their old values and takes every other bit from the (filtered) data. It always ORs in 0xA0000000.
- R4: A status write with bit 7 set stores the data unfiltered, including bit 6. It raises `periph_rst_pulse` for exactly the one cycle after the write edge.
- R5: If bit 7 is clear, a set bit 6 is dropped before storing. A write of exactly 0 stores bit 6 (0x40) instead.
- R6: `dma_en_out` rises after a status write that sets bit 9 while it was clear. It falls after one that clears bit 9 while it was set. It otherwise holds.
- R7: Status bit 0 follows `periph_irq_in`, one edge later. `irq_out` is bit 0 AND bit 4 (the interrupt enable). A change to bit 4 shows on `irq_out` right after its write edge.
- R8: Any write to the address counter sets status bit 26, which stays set until reset.
- R9: A `xfer_done` strobe adds `xfer_len` to the address counter. If a counter write happens in the same cycle, the sum uses the written value.
- R10: A request whose `req_be` is not 4'hF raises `rsp_err` in the same cycle. It does not write, and it reads back 0.
- R11: A read returns the selected register on `rsp_rdata` in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset inside the 32-byte window |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, combinational |
| rsp_err | output | 1 | Rejected partial-width request |
| periph_irq_in | input | 1 | Interrupt level from the peripheral |
| xfer_done | input | 1 | One-cycle strobe: a transfer has completed |
| xfer_len | input | 16 | Byte length of the completed transfer |
| irq_out | output | 1 | Gated interrupt |
| dma_en_out | output | 1 | DMA enable level |
| periph_rst_pulse | output | 1 | One-cycle reset strobe to the peripheral |

## Verification
The assertions assume that the bus, the peripheral and the transfer engine change their inputs only between clock edges. They also assume `xfer_done` is a single-cycle strobe whose length is valid while the strobe is high. The bench drives every input at the falling edge and returns it to idle one cycle later. It never holds a request across two edges, so each write commits exactly once. It samples combinational read data shortly after driving the request and before the next rising edge.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NREG   = 4;
  localparam int unsigned IDX_W  = $clog2(NREG);

  localparam logic [WORD_W-1:0] CSR_RO_MASK = 32'hFE00_0007;
  localparam logic [WORD_W-1:0] CSR_VERSION = 32'hA000_0000;
  localparam logic [WORD_W-1:0] CSR_DRAIN   = 32'h0000_0040;

  localparam int unsigned B_PEND   = 0;
  localparam int unsigned B_IEN    = 4;
  localparam int unsigned B_DRAIN  = 6;
  localparam int unsigned B_CRST   = 7;
  localparam int unsigned B_EN     = 9;
  localparam int unsigned B_LOADED = 26;

  localparam int unsigned IDX_CSR  = 0;
  localparam int unsigned IDX_ADDR = 1;

  // Applies the reset/drain/zero rules to incoming status data.
  function automatic logic [WORD_W-1:0] csr_filter(input logic [WORD_W-1:0] wd);
    logic [WORD_W-1:0] r;
    if (wd[B_CRST])       r = wd;
    else if (wd[B_DRAIN]) r = wd & ~CSR_DRAIN;
    else if (wd == '0)    r = CSR_DRAIN;
    else                  r = wd;
    return r;
  endfunction

  // Combines old protected bits, filtered write data and the version field.
  function automatic logic [WORD_W-1:0] csr_merge(input logic [WORD_W-1:0] old,
                                                  input logic [WORD_W-1:0] wd);
    return (old & CSR_RO_MASK) | (csr_filter(wd) & ~CSR_RO_MASK) | CSR_VERSION;
  endfunction

  function automatic logic [WORD_W-1:0] addr_step(input logic [WORD_W-1:0] base,
                                                  input logic [WORD_W-1:0] len);
    return base + len;
  endfunction
endpackage

// File: rtl/dma_chan_decode.sv
module dma_chan_decode
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [NREG-1:0]   wr_en,
  output logic              rd_ok,
  output logic              acc_err
);
  logic full_word;
  logic unused_addr_bits;

  assign full_word = (req_be == 4'hF);
  assign sel_idx   = req_addr[IDX_W+1:2];
  assign acc_err   = req_valid && !full_word;
  assign rd_ok     = req_valid && !req_write && full_word;
  assign unused_addr_bits = &{1'b0, req_addr[1:0], req_addr[ADDR_W-1:IDX_W+2]};

  for (genvar g = 0; g < NREG; g++) begin : g_wr
    assign wr_en[g] = req_valid && req_write && full_word && (sel_idx == g[IDX_W-1:0]);
  end
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              irq_in,
  input  logic              loaded_set,
  output logic [WORD_W-1:0] csr_q,
  output logic              irq_out,
  output logic              dma_en,
  output logic              rst_pulse
);
  logic [WORD_W-1:0] csr_d;
  logic en_rise, en_fall;

  always_comb begin
    csr_d = wr ? csr_merge(csr_q, wdata) : csr_q;
    csr_d[B_PEND] = irq_in;
    if (loaded_set) csr_d[B_LOADED] = 1'b1;
  end

  assign en_rise = wr &&  wdata[B_EN] && !csr_q[B_EN];
  assign en_fall = wr && !wdata[B_EN] &&  csr_q[B_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q     <= CSR_VERSION;
      dma_en    <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      csr_q     <= csr_d;
      rst_pulse <= wr && wdata[B_CRST];
      if (en_rise)      dma_en <= 1'b1;
      else if (en_fall) dma_en <= 1'b0;
    end
  end

  assign irq_out = csr_q[B_PEND] && csr_q[B_IEN];
endmodule

// File: rtl/dma_chan_datapath.sv
module dma_chan_datapath
  import dma_chan_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NREG-1:0]              wr_en,
  input  logic [WORD_W-1:0]            wdata,
  input  logic                         xfer_done,
  input  logic [LEN_W-1:0]             xfer_len,
  output logic [NREG-1:1][WORD_W-1:0]  regs_q
);
  logic [WORD_W-1:0] addr_base, addr_inc;

  assign addr_base = wr_en[IDX_ADDR] ? wdata : regs_q[IDX_ADDR];
  assign addr_inc  = xfer_done ? WORD_W'(xfer_len) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q[IDX_ADDR] <= '0;
    else        regs_q[IDX_ADDR] <= addr_step(addr_base, addr_inc);
  end

  for (genvar g = IDX_ADDR + 1; g < NREG; g++) begin : g_gp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        regs_q[g] <= '0;
      else if (wr_en[g]) regs_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic              periph_irq_in,
  input  logic              xfer_done,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              irq_out,
  output logic              dma_en_out,
  output logic              periph_rst_pulse
);
  logic [IDX_W-1:0]           sel_idx;
  logic [NREG-1:0]            wr_en;
  logic                       rd_ok;
  logic [WORD_W-1:0]          csr_q;
  logic [NREG-1:1][WORD_W-1:0] dp_q;
  logic [NREG-1:0][WORD_W-1:0] all_q;

  // Named events for the checker
  logic wr_csr, wr_addr, wr_any;
  logic [WORD_W-1:0] addr_q;

  dma_chan_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .sel_idx(sel_idx), .wr_en(wr_en), .rd_ok(rd_ok),
    .acc_err(rsp_err)
  );

  dma_chan_csr u_csr (
    .clk(clk), .rst_n(rst_n), .wr(wr_csr), .wdata(req_wdata),
    .irq_in(periph_irq_in), .loaded_set(wr_addr), .csr_q(csr_q),
    .irq_out(irq_out), .dma_en(dma_en_out), .rst_pulse(periph_rst_pulse)
  );

  dma_chan_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(req_wdata),
    .xfer_done(xfer_done), .xfer_len(xfer_len), .regs_q(dp_q)
  );

  assign wr_csr  = wr_en[IDX_CSR];
  assign wr_addr = wr_en[IDX_ADDR];
  assign wr_any  = |wr_en;
  assign addr_q  = dp_q[IDX_ADDR];

  always_comb begin
    all_q[0] = csr_q;
    for (int i = 1; i < NREG; i++) all_q[i] = dp_q[i];
  end

  assign rsp_rdata = rd_ok ? all_q[sel_idx] : '0;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int unsigned LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      req_wdata,
  input logic             periph_irq_in,
  input logic             xfer_done,
  input logic [LEN_W-1:0] xfer_len,
  input logic             irq_out,
  input logic             dma_en_out,
  input logic             periph_rst_pulse,
  input logic             rsp_err,
  input logic             wr_csr,
  input logic             wr_addr,
  input logic             wr_any,
  input logic [31:0]      csr_q,
  input logic [31:0]      addr_q
);
  p_version_r3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[31:29] == 3'b101);

  p_pulse_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_pulse |-> $past(wr_csr && req_wdata[7]));

  p_en_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_en_out) |-> $past(wr_csr && req_wdata[9]));

  p_en_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_en_out) |-> $past(wr_csr && !req_wdata[9]));

  p_irq_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(periph_irq_in) |-> !irq_out);

  p_loaded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_addr) |-> csr_q[26]);

  p_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(xfer_done && !wr_addr) |-> addr_q == $past(addr_q) + 32'($past(xfer_len)));

  p_err_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !wr_any);
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_wdata(req_wdata), .periph_irq_in(periph_irq_in),
  .xfer_done(xfer_done), .xfer_len(xfer_len), .irq_out(irq_out),
  .dma_en_out(dma_en_out), .periph_rst_pulse(periph_rst_pulse), .rsp_err(rsp_err),
  .wr_csr(wr_csr), .wr_addr(wr_addr), .wr_any(wr_any), .csr_q(csr_q), .addr_q(addr_q)
);

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [4:0]  req_addr = '0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        periph_irq_in = 0, xfer_done = 0;
  logic [15:0] xfer_len = '0;
  logic        irq_out, dma_en_out, periph_rst_pulse;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_chan_regs uut (.*);

  localparam int NV = 8;
  localparam logic [4:0]  V_WA [NV] = '{5'h08, 5'h0C, 5'h18, 5'h00, 5'h00, 5'h00, 5'h00, 5'h04};
  localparam logic [31:0] V_WD [NV] = '{32'h1234_5678, 32'hCAFE_F00D, 32'h0BAD_BEEF, 32'h0000_0110,
                                        32'h0, 32'h0000_0050, 32'hFFFF_FF3F, 32'h0000_1000};
  localparam logic [4:0]  V_RA [NV] = '{5'h08, 5'h1C, 5'h08, 5'h10, 5'h00, 5'h00, 5'h00, 5'h14};
  localparam logic [31:0] V_EX [NV] = '{32'h1234_5678, 32'hCAFE_F00D, 32'h0BAD_BEEF, 32'hA000_0110,
                                        32'hA000_0040, 32'hA000_0010, 32'hA1FF_FF38, 32'h0000_1000};
  localparam string       V_RQ [NV] = '{"R1", "R1", "R1", "R3", "R5", "R5", "R3", "R11"};

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  // Called at a falling edge; write commits at the next rising edge.
  task automatic wr(logic [4:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_be = 4'hF;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    #1 d = rsp_rdata;
    req_valid = 0;
  endtask

  task automatic reset_dut();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    reset_dut();

    // R2 reset state
    rd(5'h00, d); check("R2", d, 32'hA000_0000);
    for (int i = 1; i < 4; i++) begin
      rd(5'(i * 4), d); check("R2", d, 32'h0);
    end
    check("R2", {29'b0, irq_out, dma_en_out, periph_rst_pulse}, 32'h0);

    // Vector table: write, then read back
    for (int i = 0; i < NV; i++) begin
      wr(V_WA[i], V_WD[i]);
      rd(V_RA[i], d);
      check(V_RQ[i], d, V_EX[i]);
    end

    reset_dut();

    // R8 loaded flag
    wr(5'h04, 32'h100);
    rd(5'h00, d); check("R8", d, 32'hA400_0000);

    // R9 advance, and same-cycle write plus advance
    xfer_done = 1; xfer_len = 16'h20;
    @(negedge clk); xfer_done = 0;
    rd(5'h04, d); check("R9", d, 32'h120);
    xfer_done = 1; xfer_len = 16'h4;
    wr(5'h04, 32'h200);
    xfer_done = 0;
    rd(5'h14, d); check("R9", d, 32'h204);

    // R4 reset strobe
    req_valid = 1; req_write = 1; req_addr = 5'h00; req_wdata = 32'hC0;
    #1 check("R4", {31'b0, periph_rst_pulse}, 32'h0);
    @(negedge clk); req_valid = 0; req_write = 0;
    check("R4", {31'b0, periph_rst_pulse}, 32'h1);
    @(negedge clk);
    check("R4", {31'b0, periph_rst_pulse}, 32'h0);
    rd(5'h00, d); check("R4", d, 32'hA400_00C0);

    // R6 enable tracking
    wr(5'h00, 32'h200);
    check("R6", {31'b0, dma_en_out}, 32'h1);
    wr(5'h00, 32'h210);
    check("R6", {31'b0, dma_en_out}, 32'h1);
    wr(5'h00, 32'h10);
    check("R6", {31'b0, dma_en_out}, 32'h0);

    // R7 pending and gating
    periph_irq_in = 1;
    @(negedge clk);
    check("R7", {31'b0, irq_out}, 32'h1);
    rd(5'h00, d); check("R7", d, 32'hA400_0011);
    wr(5'h00, 32'h0);
    check("R7", {31'b0, irq_out}, 32'h0);
    rd(5'h00, d); check("R5", d, 32'hA400_0041);
    periph_irq_in = 0;
    @(negedge clk);
    rd(5'h00, d); check("R7", d, 32'hA400_0040);

    // R10 partial-width requests
    req_valid = 1; req_write = 1; req_addr = 5'h08; req_wdata = 32'h55; req_be = 4'h3;
    #1 check("R10", {31'b0, rsp_err}, 32'h1);
    @(negedge clk); req_valid = 0; req_write = 0; req_be = 4'hF;
    rd(5'h08, d); check("R10", d, 32'h0);
    req_valid = 1; req_addr = 5'h00; req_be = 4'h1;
    #1 check("R10", rsp_rdata, 32'h0);
    check("R10", {31'b0, rsp_err}, 32'h1);
    req_valid = 0; req_be = 4'hF;
    #1 check("R10", {31'b0, rsp_err}, 32'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule